// File: doc/BRIEF.md
# Overlapped Windowed Register File

This block is the integer register file of a processor whose registers are arranged in rotating windows. Each instruction sees 32 architectural registers. Indices 0 to 7 name eight globals that every window shares. Indices 8 to 31 name three groups of eight registers (outs, locals and ins) that belong to the window selected by a current-window pointer.

Adjacent windows overlap by one group. The outs of the calling window are physically the ins of the window entered by a save, so arguments and results pass between caller and callee without copying. Physical storage holds the 8 globals plus 16 registers per window. The window count is a parameter between 2 and 32.

The file has two combinational read ports and one write port. A save moves the pointer down by one window and a restore moves it up by one, both wrapping. A save or restore also adds the two read-port values from the old window and writes the sum into the destination register of the new window. A per-window invalid mask stops a move into a window that software has marked unavailable, and the block reports this as an overflow (on a save) or an underflow (on a restore).

Top module: `regwin_file`

## Requirements
- R1: After synchronous reset the window pointer is 0, both flags are low, and every architectural register reads 0 in every window.
- R2: Register index 0 always reads 0 on both ports. A write to index 0 is discarded, even when a read of index 0 happens in the same cycle.
- R3: Indices 0-7 reach the same 8 global registers from every window. Indices 16-23 (locals) are private to each window.
- R4: The outs (indices 8-15, slot k = index-8) of window w are the same physical registers as the ins (indices 24-31, slot k = index-24) of window (w-1) mod NWIN.
- R5: An accepted save sets the pointer to (cwp-1) mod NWIN, and an accepted restore sets it to (cwp+1) mod NWIN. The new value is visible after the clock edge.
- R6: A save whose target window has its win_invalid bit set leaves the pointer unchanged and performs no write. win_overflow is then high for exactly the one cycle after that edge.
- R7: A restore whose target window has its win_invalid bit set leaves the pointer unchanged and performs no write. win_underflow is then high for exactly the one cycle after that edge.
- R8: During a save or restore with wr_en high, the value written is the sum of the stored values at rd_a_idx and rd_b_idx in the old window. It goes to wr_idx in the new window, and wr_data is ignored.
- R9: When a read port addresses the same physical register that is being written in that cycle, the port returns the value being written. This also holds when the write lands in the new window of a move.
- R10: When save_req and restore_req are both high, the save is performed and the restore is ignored.
- R11: In a cycle with neither save_req nor restore_req, the pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 5 | Architectural index, read port A |
| rd_b_idx | input | 5 | Architectural index, read port B |
| rd_a_data | output | XLEN | Read data, port A (combinational) |
| rd_b_data | output | XLEN | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural destination index |
| wr_data | input | XLEN | Write data for ordinary writes |
| save_req | input | 1 | Move to the callee window (pointer minus one) |
| restore_req | input | 1 | Move to the caller window (pointer plus one) |
| win_invalid | input | NWIN | One bit per window; a set bit blocks a move into that window |
| cwp | output | $clog2(NWIN) | Current window pointer |
| win_overflow | output | 1 | One-cycle pulse after a blocked save |
| win_underflow | output | 1 | One-cycle pulse after a blocked restore |

## Verification
The bench uses four windows. It first fills every register of every window with a value that encodes both the window and the index, then reads all 32 indices back in each window. A wrong group decode, a wrong overlap direction or a missing wrap therefore shows up as a value from the wrong window or the wrong slot. Targeted patterns then write an out and read it as an in after a save, drive blocked saves and restores against chosen mask bits, and check the save-sum with distinct operand values so that wr_data leaking through is visible. They also read a register while it is being written, both within one window and across a move, and raise both move requests together.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    localparam int ARCH_IDX_W  = 5;
    localparam int GROUP_REGS  = 8;
    localparam int WIN_STRIDE  = 16;
    localparam int NUM_GLOBALS = 8;
    localparam int MIN_WINDOWS = 2;
    localparam int MAX_WINDOWS = 32;

    typedef logic [ARCH_IDX_W-1:0] arch_idx_t;

    // group select taken from the top two index bits
    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_OUT    = 2'd1,
        GRP_LOCAL  = 2'd2,
        GRP_IN     = 2'd3
    } reg_group_e;

    typedef enum logic [1:0] {
        WOP_NONE    = 2'd0,
        WOP_SAVE    = 2'd1,
        WOP_RESTORE = 2'd2
    } win_op_e;

    typedef struct packed {
        logic overflow;
        logic underflow;
    } win_flags_t;

    function automatic reg_group_e group_of(arch_idx_t idx);
        return reg_group_e'(idx[4:3]);
    endfunction

    // neighbour window, wrapping at both ends
    function automatic int unsigned win_step(int unsigned w, int unsigned nwin, logic down);
        if (down)
            return (w == 0) ? nwin - 1 : w - 1;
        return (w == nwin - 1) ? 0 : w + 1;
    endfunction

    // physical slot: globals first, then 16 per window (ins at +0, locals at +8);
    // the outs of a window live in the in-slots of the window below it
    function automatic int unsigned phys_of(arch_idx_t idx, int unsigned w, int unsigned nwin);
        int unsigned slot;
        slot = {29'd0, idx[2:0]};
        case (group_of(idx))
            GRP_GLOBAL: return slot;
            GRP_OUT:    return NUM_GLOBALS + win_step(w, nwin, 1'b1) * WIN_STRIDE + slot;
            GRP_LOCAL:  return NUM_GLOBALS + w * WIN_STRIDE + GROUP_REGS + slot;
            default:    return NUM_GLOBALS + w * WIN_STRIDE + slot;
        endcase
    endfunction

endpackage

// File: rtl/regwin_xlate.sv
module regwin_xlate
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int WW   = $clog2(NWIN),
    parameter int PW   = 8
) (
    input  arch_idx_t       idx,
    input  logic [WW-1:0]   win,
    output logic [PW-1:0]   phys,
    output logic            is_zero
);

    logic [31:0] phys_full;

    always_comb begin
        phys_full = phys_of(idx, 32'(win), 32'(NWIN));
        phys      = phys_full[PW-1:0];
        is_zero   = (idx == '0);
    end

endmodule

// File: rtl/regwin_ptr.sv
module regwin_ptr
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int WW   = $clog2(NWIN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            save_req,
    input  logic            restore_req,
    input  logic [NWIN-1:0] win_invalid,
    output logic [WW-1:0]   cwp,
    output logic [WW-1:0]   wr_win,
    output logic            op_try,
    output logic            op_block,
    output win_flags_t      flags
);

    win_op_e       op;
    logic [31:0]   tgt_full;
    logic [WW-1:0] target;
    logic          move;
    logic [WW-1:0] cwp_q;
    win_flags_t    flags_q;

    // save has priority when both requests arrive together
    always_comb begin
        if (save_req)
            op = WOP_SAVE;
        else if (restore_req)
            op = WOP_RESTORE;
        else
            op = WOP_NONE;
    end

    always_comb begin
        tgt_full = win_step(32'(cwp_q), 32'(NWIN), op == WOP_SAVE);
        target   = tgt_full[WW-1:0];
        op_try   = (op != WOP_NONE);
        op_block = op_try && win_invalid[target];
        move     = op_try && !op_block;
        wr_win   = move ? target : cwp_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp_q   <= '0;
            flags_q <= '0;
        end else begin
            if (move)
                cwp_q <= target;
            flags_q.overflow  <= op_block && (op == WOP_SAVE);
            flags_q.underflow <= op_block && (op == WOP_RESTORE);
        end
    end

    assign cwp   = cwp_q;
    assign flags = flags_q;

endmodule

// File: rtl/regwin_store.sv
module regwin_store #(
    parameter int XLEN  = 32,
    parameter int NPHYS = 136,
    parameter int PW    = 8,
    parameter int NRD   = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [PW-1:0]            wr_phys,
    input  logic [XLEN-1:0]          wr_value,
    input  logic [NRD-1:0][PW-1:0]   rd_phys,
    input  logic [NRD-1:0]           rd_zero,
    output logic [NRD-1:0][XLEN-1:0] raw_data,
    output logic [NRD-1:0][XLEN-1:0] rd_data
);

    logic [XLEN-1:0] mem [NPHYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < NPHYS; e++)
                mem[e] <= '0;
        end else if (we) begin
            mem[wr_phys] <= wr_value;
        end
    end

    // raw reads see stored state only; bypassed reads also see this cycle's write
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            raw_data[p] = mem[rd_phys[p]];
            if (rd_zero[p])
                rd_data[p] = '0;
            else if (we && (wr_phys == rd_phys[p]))
                rd_data[p] = wr_value;
            else
                rd_data[p] = raw_data[p];
        end
    end

endmodule

// File: rtl/regwin_file.sv
module regwin_file
    import regwin_pkg::*;
#(
    parameter int  NWIN = 8,
    parameter int  XLEN = 32,
    localparam int WW   = $clog2(NWIN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [4:0]      rd_a_idx,
    input  logic [4:0]      rd_b_idx,
    output logic [XLEN-1:0] rd_a_data,
    output logic [XLEN-1:0] rd_b_data,
    input  logic            wr_en,
    input  logic [4:0]      wr_idx,
    input  logic [XLEN-1:0] wr_data,
    input  logic            save_req,
    input  logic            restore_req,
    input  logic [NWIN-1:0] win_invalid,
    output logic [WW-1:0]   cwp,
    output logic            win_overflow,
    output logic            win_underflow
);

    localparam int NPHYS  = NUM_GLOBALS + WIN_STRIDE * NWIN;
    localparam int PW     = $clog2(NPHYS);
    localparam int NPORTS = 3;
    localparam int WRP    = NPORTS - 1;

    if (NWIN < MIN_WINDOWS || NWIN > MAX_WINDOWS) begin : g_bad_cfg
        $error("regwin_file: NWIN out of range");
    end

    logic [WW-1:0] wr_win;
    logic          op_try;
    logic          op_block;
    win_flags_t    flags;

    regwin_ptr #(.NWIN(NWIN), .WW(WW)) u_ptr (
        .clk         (clk),
        .rst         (rst),
        .save_req    (save_req),
        .restore_req (restore_req),
        .win_invalid (win_invalid),
        .cwp         (cwp),
        .wr_win      (wr_win),
        .op_try      (op_try),
        .op_block    (op_block),
        .flags       (flags)
    );

    // ports 0,1 read in the current window; port 2 writes in the move target
    arch_idx_t     port_idx  [NPORTS];
    logic [WW-1:0] port_win  [NPORTS];
    logic [PW-1:0] port_phys [NPORTS];
    logic          port_zero [NPORTS];

    always_comb begin
        port_idx[0] = rd_a_idx;
        port_idx[1] = rd_b_idx;
        port_idx[2] = wr_idx;
        port_win[0] = cwp;
        port_win[1] = cwp;
        port_win[2] = wr_win;
    end

    for (genvar i = 0; i < NPORTS; i++) begin : g_xl
        regwin_xlate #(.NWIN(NWIN), .WW(WW), .PW(PW)) u_xl (
            .idx     (port_idx[i]),
            .win     (port_win[i]),
            .phys    (port_phys[i]),
            .is_zero (port_zero[i])
        );
    end

    logic [1:0][PW-1:0]   rd_phys;
    logic [1:0]           rd_zero;
    logic [1:0][XLEN-1:0] raw_data;
    logic [1:0][XLEN-1:0] rd_data;
    logic [XLEN-1:0]      wr_value;
    logic                 we_eff;

    always_comb begin
        rd_phys[0] = port_phys[0];
        rd_phys[1] = port_phys[1];
        rd_zero[0] = port_zero[0];
        rd_zero[1] = port_zero[1];
        wr_value   = op_try ? (raw_data[0] + raw_data[1]) : wr_data;
        we_eff     = wr_en && !op_block && !port_zero[WRP];
    end

    regwin_store #(.XLEN(XLEN), .NPHYS(NPHYS), .PW(PW), .NRD(2)) u_store (
        .clk      (clk),
        .rst      (rst),
        .we       (we_eff),
        .wr_phys  (port_phys[WRP]),
        .wr_value (wr_value),
        .rd_phys  (rd_phys),
        .rd_zero  (rd_zero),
        .raw_data (raw_data),
        .rd_data  (rd_data)
    );

    assign rd_a_data     = rd_data[0];
    assign rd_b_data     = rd_data[1];
    assign win_overflow  = flags.overflow;
    assign win_underflow = flags.underflow;

endmodule

// File: rtl/regwin_file_chk.sv
module regwin_file_chk #(
    parameter int NWIN = 8,
    parameter int XLEN = 32,
    parameter int WW   = $clog2(NWIN)
) (
    input logic            clk,
    input logic            rst,
    input logic [4:0]      rd_a_idx,
    input logic [4:0]      rd_b_idx,
    input logic [XLEN-1:0] rd_a_data,
    input logic [XLEN-1:0] rd_b_data,
    input logic            save_req,
    input logic            restore_req,
    input logic [NWIN-1:0] win_invalid,
    input logic [WW-1:0]   cwp,
    input logic            win_overflow,
    input logic            win_underflow
);

    logic [WW-1:0] dn_win;
    logic [WW-1:0] up_win;

    always_comb begin
        dn_win = (cwp == '0) ? WW'(NWIN - 1) : cwp - 1'b1;
        up_win = (cwp == WW'(NWIN - 1)) ? '0 : cwp + 1'b1;
    end

    // R1
    cwp_range_chk: assert property (@(posedge clk) disable iff (rst)
        32'(cwp) < NWIN);

    // R2
    zero_a_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == 5'd0) |-> (rd_a_data == '0));

    // R2
    zero_b_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_b_idx == 5'd0) |-> (rd_b_data == '0));

    // R5
    save_move_chk: assert property (@(posedge clk) disable iff (rst)
        (save_req && !win_invalid[dn_win]) |=> (cwp == $past(dn_win)));

    // R5
    restore_move_chk: assert property (@(posedge clk) disable iff (rst)
        (restore_req && !save_req && !win_invalid[up_win]) |=> (cwp == $past(up_win)));

    // R6
    overflow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        win_overflow |-> $stable(cwp));

    // R7
    underflow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        win_underflow |-> $stable(cwp));

    // R6
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(win_overflow && win_underflow));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!save_req && !restore_req) |=> $stable(cwp));

endmodule

bind regwin_file regwin_file_chk #(.NWIN(NWIN), .XLEN(XLEN)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .rd_a_idx      (rd_a_idx),
    .rd_b_idx      (rd_b_idx),
    .rd_a_data     (rd_a_data),
    .rd_b_data     (rd_b_data),
    .save_req      (save_req),
    .restore_req   (restore_req),
    .win_invalid   (win_invalid),
    .cwp           (cwp),
    .win_overflow  (win_overflow),
    .win_underflow (win_underflow)
);

// File: tb/regwin_file_test.sv
module regwin_file_test;

    localparam int NW    = 4;
    localparam int XL    = 32;
    localparam int WWT   = $clog2(NW);
    localparam int NPHYT = 8 + 16 * NW;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [4:0]     rd_a_idx = '0;
    logic [4:0]     rd_b_idx = '0;
    logic [XL-1:0]  rd_a_data;
    logic [XL-1:0]  rd_b_data;
    logic           wr_en = 1'b0;
    logic [4:0]     wr_idx = '0;
    logic [XL-1:0]  wr_data = '0;
    logic           save_req = 1'b0;
    logic           restore_req = 1'b0;
    logic [NW-1:0]  win_invalid = '0;
    logic [WWT-1:0] cwp;
    logic           win_overflow;
    logic           win_underflow;

    int checks = 0;
    int errors = 0;
    int mcwp   = 0;
    logic [XL-1:0] mdl [NPHYT];

    always #5 clk = ~clk;

    regwin_file #(.NWIN(NW), .XLEN(XL)) uut (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .save_req(save_req), .restore_req(restore_req),
        .win_invalid(win_invalid), .cwp(cwp),
        .win_overflow(win_overflow), .win_underflow(win_underflow)
    );

    // expected physical home of an index, from the requirement text
    function automatic int mph(int idx, int w);
        if (idx < 8)  return idx;
        if (idx < 16) return 8 + ((w + NW - 1) % NW) * 16 + (idx - 8);
        if (idx < 24) return 8 + w * 16 + 8 + (idx - 16);
        return 8 + w * 16 + (idx - 24);
    endfunction

    function automatic logic [XL-1:0] mget(int idx, int w);
        if (idx == 0) return '0;
        return mdl[mph(idx, w)];
    endfunction

    task automatic check(input logic [XL-1:0] act, input logic [XL-1:0] exp,
                         input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input logic sv, input logic rs, input logic we,
                       input int wi, input logic [XL-1:0] wd);
        @(negedge clk);
        save_req = sv; restore_req = rs; wr_en = we;
        wr_idx = 5'(wi); wr_data = wd;
        @(posedge clk);
        #1;
        save_req = 1'b0; restore_req = 1'b0; wr_en = 1'b0;
    endtask

    task automatic wr(input int idx, input logic [XL-1:0] val);
        cyc(1'b0, 1'b0, 1'b1, idx, val);
        if (idx != 0) mdl[mph(idx, mcwp)] = val;
    endtask

    task automatic chk_reg(input int idx, input logic [XL-1:0] exp, input string req);
        @(negedge clk);
        rd_a_idx = 5'(idx); rd_b_idx = 5'(idx);
        #1;
        check(rd_a_data, exp, req, $sformatf("port A r%0d win %0d", idx, mcwp));
        check(rd_b_data, exp, req, $sformatf("port B r%0d win %0d", idx, mcwp));
    endtask

    task automatic do_restore();
        cyc(1'b0, 1'b1, 1'b0, 0, '0);
        mcwp = (mcwp + 1) % NW;
        check(32'(cwp), 32'(mcwp), "R5", "cwp after restore");
    endtask

    task automatic do_save();
        cyc(1'b1, 1'b0, 1'b0, 0, '0);
        mcwp = (mcwp + NW - 1) % NW;
        check(32'(cwp), 32'(mcwp), "R5", "cwp after save");
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [XL-1:0] keep;
        logic [XL-1:0] sum;
        for (int e = 0; e < NPHYT; e++) mdl[e] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        check(32'(cwp), 0, "R1", "cwp after reset");
        check({31'd0, win_overflow}, 0, "R1", "overflow after reset");
        check({31'd0, win_underflow}, 0, "R1", "underflow after reset");
        for (int i = 0; i < 32; i++) chk_reg(i, '0, "R1");

        // R2 zero register: write discarded, same-cycle read still zero
        wr(0, 32'hDEADBEEF);
        chk_reg(0, '0, "R2");
        @(negedge clk);
        rd_a_idx = 5'd0; wr_en = 1'b1; wr_idx = 5'd0; wr_data = 32'hFFFF0000;
        #1 check(rd_a_data, '0, "R2", "r0 read during r0 write");
        @(posedge clk); #1 wr_en = 1'b0;

        // sweep: fill every window with window/index-coded values
        for (int w = 0; w < NW; w++) begin
            for (int i = 1; i < 32; i++)
                wr(i, 32'hC0DE0000 | 32'(w << 8) | 32'(i));
            do_restore();
        end
        // read back every index in every window
        for (int w = 0; w < NW; w++) begin
            for (int i = 0; i < 32; i++)
                chk_reg(i, mget(i, mcwp), (i < 8 || (i >= 16 && i < 24)) ? "R3" : "R4");
            do_restore();
        end

        // R4 explicit overlap through a save (with wrap 0 -> NW-1)
        wr(8, 32'h0A0A0001);
        do_save();
        chk_reg(24, 32'h0A0A0001, "R4");
        do_restore();

        // R3 globals shared, locals private
        wr(3, 32'h61061003);
        wr(16, 32'h10CA1000);
        do_restore();
        chk_reg(3, 32'h61061003, "R3");
        chk_reg(16, mget(16, mcwp), "R3");
        do_save();

        // R6 blocked save
        win_invalid = 4'b1000;
        keep = mget(20, mcwp);
        cyc(1'b1, 1'b0, 1'b1, 20, 32'h12345678);
        check({31'd0, win_overflow}, 1, "R6", "overflow pulse");
        check(32'(cwp), 32'(mcwp), "R6", "cwp held on overflow");
        @(posedge clk); #1;
        check({31'd0, win_overflow}, 0, "R6", "overflow lasts one cycle");
        chk_reg(20, keep, "R6");

        // R7 blocked restore
        win_invalid = 4'b0010;
        keep = mget(21, mcwp);
        cyc(1'b0, 1'b1, 1'b1, 21, 32'h87654321);
        check({31'd0, win_underflow}, 1, "R7", "underflow pulse");
        check({31'd0, win_overflow}, 0, "R7", "no overflow on restore");
        check(32'(cwp), 32'(mcwp), "R7", "cwp held on underflow");
        @(posedge clk); #1;
        check({31'd0, win_underflow}, 0, "R7", "underflow lasts one cycle");
        chk_reg(21, keep, "R7");
        win_invalid = '0;

        // R8 save adds old-window operands into new-window destination
        wr(16, 32'd100);
        wr(17, 32'd23);
        keep = mget(18, mcwp);
        rd_a_idx = 5'd16; rd_b_idx = 5'd17;
        cyc(1'b1, 1'b0, 1'b1, 18, 32'hFFFFFFFF);
        mcwp = (mcwp + NW - 1) % NW;
        mdl[mph(18, mcwp)] = 32'd123;
        check(32'(cwp), 32'(mcwp), "R8", "cwp after summing save");
        chk_reg(18, 32'd123, "R8");
        do_restore();
        chk_reg(18, keep, "R8");

        // R9 bypass within a window
        @(negedge clk);
        rd_a_idx = 5'd5; rd_b_idx = 5'd6;
        wr_en = 1'b1; wr_idx = 5'd5; wr_data = 32'h5555AAAA;
        #1;
        check(rd_a_data, 32'h5555AAAA, "R9", "bypass same register");
        check(rd_b_data, mget(6, mcwp), "R9", "other port not bypassed");
        @(posedge clk); #1 wr_en = 1'b0;
        mdl[mph(5, mcwp)] = 32'h5555AAAA;

        // R9 bypass across a save: old out slot 0 is new in slot 0
        sum = mget(8, mcwp) + mget(9, mcwp);
        @(negedge clk);
        rd_a_idx = 5'd8; rd_b_idx = 5'd9;
        save_req = 1'b1; wr_en = 1'b1; wr_idx = 5'd24; wr_data = '0;
        #1 check(rd_a_data, sum, "R9", "bypass across window move");
        @(posedge clk); #1 save_req = 1'b0; wr_en = 1'b0;
        mcwp = (mcwp + NW - 1) % NW;
        mdl[mph(24, mcwp)] = sum;
        chk_reg(24, sum, "R9");
        do_restore();

        // R10 save wins over restore
        cyc(1'b1, 1'b1, 1'b0, 0, '0);
        mcwp = (mcwp + NW - 1) % NW;
        check(32'(cwp), 32'(mcwp), "R10", "both requests act as save");
        do_restore();

        // R11 pointer holds without requests
        wr(7, 32'h77777777);
        check(32'(cwp), 32'(mcwp), "R11", "cwp after plain write");
        cyc(1'b0, 1'b0, 1'b0, 0, '0);
        check(32'(cwp), 32'(mcwp), "R11", "cwp after idle cycle");
        chk_reg(7, 32'h77777777, "R11");

        report();
    end

endmodule